// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block drives a parallel active-matrix color TFT panel. It produces a panel clock, a line sync, a frame sync and a data-ready qualifier, and it passes pixel words from an upstream source to the panel data bus. Each pixel period lasts two system clocks. The panel clock rises when new values are launched and falls halfway through the pixel, so the panel latches on the falling edge. Setting the clock inversion moves both events to the opposite edges.

The geometry of both axes is set on input ports. Each axis has a sync length, a lead-in (blanking between sync and data), an active count and a trail (blanking after data). The block keeps a private copy of these values and refreshes it only when a new frame begins. A write that arrives in the middle of a frame therefore never produces a mixed frame. Every output has its own polarity select. The pixel source is paced by a valid/ready handshake that requests exactly one word for each active pixel.

Top module: `tft_timing_gen`

## Requirements
- R1: While reset is asserted, and while `en` is low, each of `pclk_o`, `hsync_o`, `vsync_o` and `drdy_o` rests at its inactive level. The inactive level is 0 when the matching invert bit is 0, and 1 when it is 1. `src_ready` is 0 and `data_o` is 0.
- R2: While enabled, the un-inverted panel clock is high for the first clock of every two-clock pixel period and low for the second. It toggles on every clock, through blanking as well. It rises on the edge where hsync, vsync, drdy and data change, and it falls midway through the pixel. `clk_inv`=1 inverts it.
- R3: The pixel position runs from 0 to H_total-1, where H_total = hsync length + h lead + h active + h trail. Hsync is asserted for the pixel positions below the hsync length, so it opens every line.
- R4: The line number advances when the pixel position wraps to 0, which is the first pixel of hsync. It runs from 0 to V_total-1. Vsync is asserted for the lines below the vsync length, so it spans whole lines and every hsync pulse inside them.
- R5: A sync length of 0 on either axis is treated as 1.
- R6: Drdy is asserted exactly when the pixel position lies in [hsync+hlead, hsync+hlead+hactive) and the line lies in [vsync+vlead, vsync+vlead+vactive).
- R7: `src_ready` is high for one clock, the second clock of the pixel that comes before each active pixel. The word on `src_data` at the end of that clock is shown on `data_o` for the whole active pixel, or 0 if `src_valid` was low. `data_o` is 0 whenever drdy is inactive.
- R8: The invert bits `hs_inv`, `vs_inv`, `de_inv` and `clk_inv` (1 = active-low or inverted) take effect on their outputs at once, with no clock delay.
- R9: The geometry inputs are captured at the first pixel of each frame. A change made during a frame affects only frames that begin after it.
- R10: When `en` is sampled low, every output is inactive after that clock edge and the position resets. The first edge that samples `en` high again starts a new frame at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| h_sync_len | input | CNT_W | Hsync length in pixels |
| h_lead_len | input | CNT_W | Blanking pixels between hsync and data |
| h_act_len | input | CNT_W | Active pixels per line |
| h_trail_len | input | CNT_W | Blanking pixels after data |
| v_sync_len | input | CNT_W | Vsync length in lines |
| v_lead_len | input | CNT_W | Blanking lines between vsync and data |
| v_act_len | input | CNT_W | Active lines per frame |
| v_trail_len | input | CNT_W | Blanking lines after data |
| hs_inv | input | 1 | Hsync polarity invert |
| vs_inv | input | 1 | Vsync polarity invert |
| de_inv | input | 1 | Data-ready polarity invert |
| clk_inv | input | 1 | Panel clock invert |
| src_valid | input | 1 | Source word available |
| src_data | input | DATA_W | Source pixel word |
| src_ready | output | 1 | Word taken at the next clock edge |
| pclk_o | output | 1 | Panel clock |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| drdy_o | output | 1 | Data-ready qualifier |
| data_o | output | DATA_W | Panel data bus |

## Verification
The first clock edge that samples `en` high shows pixel 0 of line 0. After that, every output moves on every second edge, except the panel clock, which moves on every edge. The invert bits act with no delay, and `src_ready` follows the registered state combinationally. A new geometry shows up only at the first pixel of the following frame. A pixel's data is taken on the same edge that makes that pixel current. The bench steps a cycle-level model of these rules once per clock, on the falling edge that follows each rising edge. At that point it compares every output against the model, so each result is checked in the exact cycle it is due, across geometry changes, zero sync lengths, source underflow and disable/re-enable.

// File: rtl/tft_tg_pkg.sv
package tft_tg_pkg;
  // Half of a pixel period: launch half (panel clock high) or latch half.
  typedef enum logic {
    PH_LAUNCH = 1'b0,
    PH_LATCH  = 1'b1
  } phase_e;

  localparam int AXIS_H = 0;
  localparam int AXIS_V = 1;
  localparam int N_AXES = 2;
endpackage

// File: rtl/tft_tg_rst_sync.sv
module tft_tg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stg_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      stg_q <= 1'b1;
      out_q <= stg_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/tft_tg_axis_cfg.sv
// Per-axis geometry shadow: captured only when load is high (frame start).
module tft_tg_axis_cfg #(
  parameter int CNT_W = 12,
  parameter int TOT_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] sync_in,
  input  logic [CNT_W-1:0] lead_in,
  input  logic [CNT_W-1:0] act_in,
  input  logic [CNT_W-1:0] trail_in,
  output logic [CNT_W-1:0] sync_sel,
  output logic [CNT_W-1:0] lead_sel,
  output logic [CNT_W-1:0] act_sel,
  output logic [TOT_W-1:0] total_q
);
  logic [CNT_W-1:0] sync_eff;
  logic [CNT_W-1:0] sync_q, lead_q, act_q;
  logic [CNT_W-1:0] sync_d, lead_d, act_d;
  logic [TOT_W-1:0] total_d;

  // A zero sync length would lose the pulse; force a minimum of one.
  assign sync_eff = (sync_in == '0) ? CNT_W'(1) : sync_in;

  always_comb begin
    sync_d  = sync_q;
    lead_d  = lead_q;
    act_d   = act_q;
    total_d = total_q;
    if (load) begin
      sync_d  = sync_eff;
      lead_d  = lead_in;
      act_d   = act_in;
      total_d = TOT_W'(sync_eff) + TOT_W'(lead_in) + TOT_W'(act_in) + TOT_W'(trail_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      lead_q  <= '0;
      act_q   <= '0;
      total_q <= '0;
    end else begin
      sync_q  <= sync_d;
      lead_q  <= lead_d;
      act_q   <= act_d;
      total_q <= total_d;
    end
  end

  // Values that apply to the position being entered this cycle.
  assign sync_sel = load ? sync_eff : sync_q;
  assign lead_sel = load ? lead_in  : lead_q;
  assign act_sel  = load ? act_in   : act_q;
endmodule

// File: rtl/tft_tg_axis_cnt.sv
module tft_tg_axis_cnt #(
  parameter int TOT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [TOT_W-1:0] total,
  output logic [TOT_W-1:0] cnt_nxt,
  output logic             last_o
);
  logic [TOT_W-1:0] cnt_q;

  assign last_o = (cnt_q == total - 1'b1);

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr) begin
      cnt_nxt = '0;
    end else if (adv) begin
      cnt_nxt = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tft_tg_window.sv
// Decodes a position into "in sync" and "in active window" flags.
module tft_tg_window #(
  parameter int CNT_W = 12,
  parameter int TOT_W = CNT_W + 2
) (
  input  logic [TOT_W-1:0] pos,
  input  logic [CNT_W-1:0] sync_len,
  input  logic [CNT_W-1:0] lead_len,
  input  logic [CNT_W-1:0] act_len,
  output logic             sync_o,
  output logic             active_o
);
  logic [TOT_W-1:0] act_start;
  logic [TOT_W-1:0] act_stop;

  assign act_start = TOT_W'(sync_len) + TOT_W'(lead_len);
  assign act_stop  = act_start + TOT_W'(act_len);
  assign sync_o    = (pos < TOT_W'(sync_len));
  assign active_o  = (pos >= act_start) && (pos < act_stop);
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_tg_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  h_sync_len,
  input  logic [CNT_W-1:0]  h_lead_len,
  input  logic [CNT_W-1:0]  h_act_len,
  input  logic [CNT_W-1:0]  h_trail_len,
  input  logic [CNT_W-1:0]  v_sync_len,
  input  logic [CNT_W-1:0]  v_lead_len,
  input  logic [CNT_W-1:0]  v_act_len,
  input  logic [CNT_W-1:0]  v_trail_len,
  input  logic              hs_inv,
  input  logic              vs_inv,
  input  logic              de_inv,
  input  logic              clk_inv,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              drdy_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int TOT_W = CNT_W + 2;

  logic rst_sync_n;

  tft_tg_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Axis arrays, index AXIS_H / AXIS_V.
  logic [CNT_W-1:0] sync_in  [N_AXES];
  logic [CNT_W-1:0] lead_in  [N_AXES];
  logic [CNT_W-1:0] act_in   [N_AXES];
  logic [CNT_W-1:0] trail_in [N_AXES];
  logic [CNT_W-1:0] sync_sel [N_AXES];
  logic [CNT_W-1:0] lead_sel [N_AXES];
  logic [CNT_W-1:0] act_sel  [N_AXES];
  logic [TOT_W-1:0] total_q  [N_AXES];
  logic [TOT_W-1:0] cnt_nxt  [N_AXES];
  logic             last     [N_AXES];
  logic             adv      [N_AXES];
  logic             sync_n   [N_AXES];
  logic             act_n    [N_AXES];

  assign sync_in[AXIS_H]  = h_sync_len;
  assign lead_in[AXIS_H]  = h_lead_len;
  assign act_in[AXIS_H]   = h_act_len;
  assign trail_in[AXIS_H] = h_trail_len;
  assign sync_in[AXIS_V]  = v_sync_len;
  assign lead_in[AXIS_V]  = v_lead_len;
  assign act_in[AXIS_V]   = v_act_len;
  assign trail_in[AXIS_V] = v_trail_len;

  // Sequencing state
  phase_e            ph_q, ph_d;
  logic              run_q, run_d;
  logic              pclk_q, pclk_d;
  logic              hs_q, hs_d;
  logic              vs_q, vs_d;
  logic              de_q, de_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic start;       // first edge with en high: enter pixel 0, line 0
  logic tick;        // end of a pixel period: advance position
  logic clr;
  logic frame_wrap;
  logic load;
  logic upd;
  logic pix_act;

  assign start      = en & ~run_q;
  assign tick       = en & run_q & (ph_q == PH_LATCH);
  assign clr        = ~(en & run_q);
  assign frame_wrap = tick & last[AXIS_H] & last[AXIS_V];
  assign load       = start | frame_wrap;
  assign upd        = start | tick;

  assign adv[AXIS_H] = tick;
  assign adv[AXIS_V] = tick & last[AXIS_H];

  for (genvar g = 0; g < N_AXES; g++) begin : g_axis
    tft_tg_axis_cfg #(
      .CNT_W(CNT_W),
      .TOT_W(TOT_W)
    ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load    (load),
      .sync_in (sync_in[g]),
      .lead_in (lead_in[g]),
      .act_in  (act_in[g]),
      .trail_in(trail_in[g]),
      .sync_sel(sync_sel[g]),
      .lead_sel(lead_sel[g]),
      .act_sel (act_sel[g]),
      .total_q (total_q[g])
    );

    tft_tg_axis_cnt #(
      .TOT_W(TOT_W)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .clr    (clr),
      .adv    (adv[g]),
      .total  (total_q[g]),
      .cnt_nxt(cnt_nxt[g]),
      .last_o (last[g])
    );

    tft_tg_window #(
      .CNT_W(CNT_W),
      .TOT_W(TOT_W)
    ) u_win (
      .pos     (cnt_nxt[g]),
      .sync_len(sync_sel[g]),
      .lead_len(lead_sel[g]),
      .act_len (act_sel[g]),
      .sync_o  (sync_n[g]),
      .active_o(act_n[g])
    );
  end

  assign pix_act   = act_n[AXIS_H] & act_n[AXIS_V];
  assign src_ready = tick & pix_act;

  // Next-state logic
  always_comb begin
    run_d  = en;
    ph_d   = ph_q;
    pclk_d = pclk_q;
    hs_d   = hs_q;
    vs_d   = vs_q;
    de_d   = de_q;
    data_d = data_q;
    if (!en) begin
      ph_d   = PH_LAUNCH;
      pclk_d = 1'b0;
      hs_d   = 1'b0;
      vs_d   = 1'b0;
      de_d   = 1'b0;
      data_d = '0;
    end else begin
      if (start || ph_q == PH_LATCH) begin
        ph_d = PH_LAUNCH;
      end else begin
        ph_d = PH_LATCH;
      end
      pclk_d = (ph_d == PH_LAUNCH);
      if (upd) begin
        hs_d   = sync_n[AXIS_H];
        vs_d   = sync_n[AXIS_V];
        de_d   = pix_act;
        data_d = (pix_act && src_valid) ? src_data : '0;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      ph_q   <= PH_LAUNCH;
      pclk_q <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      de_q   <= 1'b0;
      data_q <= '0;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      pclk_q <= pclk_d;
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      de_q   <= de_d;
      data_q <= data_d;
    end
  end

  // Polarity is applied on the way out.
  assign pclk_o  = pclk_q ^ clk_inv;
  assign hsync_o = hs_q ^ hs_inv;
  assign vsync_o = vs_q ^ vs_inv;
  assign drdy_o  = de_q ^ de_inv;
  assign data_o  = data_q;
endmodule

// File: rtl/tft_tg_chk.sv
module tft_tg_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              run_q,
  input logic              hs_inv,
  input logic              vs_inv,
  input logic              de_inv,
  input logic              clk_inv,
  input logic              pclk_o,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              drdy_o,
  input logic              src_ready,
  input logic [DATA_W-1:0] data_o
);
  logic pclk_raw, hs_raw, vs_raw, de_raw;

  assign pclk_raw = pclk_o ^ clk_inv;
  assign hs_raw   = hsync_o ^ hs_inv;
  assign vs_raw   = vsync_o ^ vs_inv;
  assign de_raw   = drdy_o ^ de_inv;

  a_r1_idle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!pclk_raw && !hs_raw && !vs_raw && !de_raw && !src_ready));

  a_r2_pclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (pclk_raw != $past(pclk_raw)));

  a_r4_vsync_opens_with_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_raw) |-> hs_raw);

  a_r4_vsync_closes_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vs_raw) && run_q) |-> hs_raw);

  a_r6_drdy_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de_raw |-> (!hs_raw && !vs_raw));

  a_r7_ready_then_drdy: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && en) |=> de_raw);

  a_r7_data_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !de_raw |-> (data_o == '0));
endmodule

bind tft_timing_gen tft_tg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .run_q    (run_q),
  .hs_inv   (hs_inv),
  .vs_inv   (vs_inv),
  .de_inv   (de_inv),
  .clk_inv  (clk_inv),
  .pclk_o   (pclk_o),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .drdy_o   (drdy_o),
  .src_ready(src_ready),
  .data_o   (data_o)
);

// File: tb/tft_timing_gen_tb.sv
module tft_timing_gen_tb;
  localparam int CW = 12;
  localparam int DW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, en;
  logic [CW-1:0] hsl, hll, hal, htl, vsl, vll, val, vtl;
  logic          hs_inv, vs_inv, de_inv, clk_inv;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          src_ready, pclk_o, hsync_o, vsync_o, drdy_o;
  logic [DW-1:0] data_o;

  tft_timing_gen #(.CNT_W(CW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .h_sync_len(hsl), .h_lead_len(hll), .h_act_len(hal), .h_trail_len(htl),
    .v_sync_len(vsl), .v_lead_len(vll), .v_act_len(val), .v_trail_len(vtl),
    .hs_inv(hs_inv), .vs_inv(vs_inv), .de_inv(de_inv), .clk_inv(clk_inv),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .pclk_o(pclk_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .drdy_o(drdy_o),
    .data_o(data_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int udf_pix = 0;

  // Reference model state
  int mh[4];
  int mv[4];
  bit m_run, m_ph, m_hs, m_vs, m_de, m_acc;
  int m_h, m_v;
  int unsigned m_data;

  task automatic chk(string tag, string sig, int unsigned act, int unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, sig, act, exp);
    end
  endtask

  function automatic bit in_win(int p, int s, int l, int a);
    return (p >= s + l) && (p < s + l + a);
  endfunction

  task automatic m_load();
    mh[0] = (hsl == 0) ? 1 : int'(hsl);
    mh[1] = int'(hll); mh[2] = int'(hal); mh[3] = int'(htl);
    mv[0] = (vsl == 0) ? 1 : int'(vsl);
    mv[1] = int'(vll); mv[2] = int'(val); mv[3] = int'(vtl);
  endtask

  task automatic m_decode();
    m_hs = (m_h < mh[0]);
    m_vs = (m_v < mv[0]);
    m_de = in_win(m_h, mh[0], mh[1], mh[2]) && in_win(m_v, mv[0], mv[1], mv[2]);
  endtask

  // One clock of the model, using the inputs the last rising edge saw.
  task automatic m_step();
    int ht, vt;
    m_acc = 0;
    if (!en) begin
      m_run = 0; m_ph = 0; m_h = 0; m_v = 0;
      m_hs = 0; m_vs = 0; m_de = 0; m_data = 0;
    end else if (!m_run) begin
      m_run = 1; m_ph = 0; m_h = 0; m_v = 0;
      m_load(); m_decode(); m_data = 0;
    end else if (!m_ph) begin
      m_ph = 1;
    end else begin
      m_ph = 0;
      ht = mh[0] + mh[1] + mh[2] + mh[3];
      vt = mv[0] + mv[1] + mv[2] + mv[3];
      if (m_h == ht - 1) begin
        m_h = 0;
        m_v = (m_v == vt - 1) ? 0 : m_v + 1;
      end else begin
        m_h++;
      end
      if (m_h == 0 && m_v == 0) m_load();
      m_decode();
      if (m_de) begin
        m_data = src_valid ? int'(src_data) : 0;
        m_acc  = src_valid;
      end else begin
        m_data = 0;
      end
    end
  endtask

  function automatic bit m_ready();
    int ht, vt, nh, nv;
    ht = mh[0] + mh[1] + mh[2] + mh[3];
    vt = mv[0] + mv[1] + mv[2] + mv[3];
    if (!(en && m_run && m_ph)) return 0;
    nh = (m_h == ht - 1) ? 0 : m_h + 1;
    nv = (m_h == ht - 1) ? ((m_v == vt - 1) ? 0 : m_v + 1) : m_v;
    return in_win(nh, mh[0], mh[1], mh[2]) && in_win(nv, mv[0], mv[1], mv[2]);
  endfunction

  task automatic cmp_all(string tag);
    chk(tag, "pclk R2 R8", int'(pclk_o),  int'((m_run && !m_ph) ^ clk_inv));
    chk(tag, "hsync R3 R8", int'(hsync_o), int'(m_hs ^ hs_inv));
    chk(tag, "vsync R4 R8", int'(vsync_o), int'(m_vs ^ vs_inv));
    chk(tag, "drdy R6 R8",  int'(drdy_o),  int'(m_de ^ de_inv));
    chk(tag, "ready R7",    int'(src_ready), int'(m_ready()));
    chk(tag, "data R7",     int'(data_o),  m_data);
  endtask

  task automatic run_cycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_step();
      cmp_all(tag);
      if (m_de && !src_valid && data_o == '0 && ((drdy_o ^ de_inv) == 1'b1)) udf_pix++;
      if (m_acc) src_data = src_data + 1'b1;
    end
  endtask

  task automatic set_geom(int a, int b, int c, int d, int e, int f, int g, int h);
    hsl = CW'(a); hll = CW'(b); hal = CW'(c); htl = CW'(d);
    vsl = CW'(e); vll = CW'(f); val = CW'(g); vtl = CW'(h);
  endtask

  // R1: reset state
  task automatic t_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmp_all("R1 reset");
    end
    rst_n = 1'b1;
    run_cycles(4, "R1 idle after reset");
  endtask

  // R2 R3 R4 R6 R7: two full frames of a small geometry
  task automatic t_frames();
    set_geom(2, 1, 4, 2, 1, 1, 3, 1);
    en = 1'b1;
    run_cycles(230, "R3 R4 frames");
  endtask

  // R8: polarity selects applied while running
  task automatic t_polarity();
    hs_inv = 1'b1; vs_inv = 1'b1; de_inv = 1'b1; clk_inv = 1'b1;
    run_cycles(120, "R8 inverted");
    hs_inv = 1'b0; de_inv = 1'b0;
    run_cycles(20, "R8 mixed");
    vs_inv = 1'b0; clk_inv = 1'b0;
  endtask

  // R9: geometry written mid-frame
  task automatic t_midframe();
    run_cycles(40, "R9 before write");
    set_geom(1, 2, 3, 1, 2, 0, 2, 2);
    run_cycles(220, "R9 after write");
  endtask

  // R5: zero sync lengths
  task automatic t_zero_sync();
    set_geom(0, 1, 3, 1, 0, 1, 2, 1);
    run_cycles(200, "R5 zero sync");
  endtask

  // R7: source underflow
  task automatic t_underflow();
    udf_pix = 0;
    src_valid = 1'b0;
    run_cycles(130, "R7 underflow");
    chk("R7 underflow", "zero pixels with drdy", int'(udf_pix > 0), 1);
    src_valid = 1'b1;
    run_cycles(20, "R7 resume");
  endtask

  // R10: disable mid-frame, then restart
  task automatic t_disable();
    set_geom(2, 1, 4, 2, 1, 1, 3, 1);
    run_cycles(37, "R10 running");
    en = 1'b0;
    run_cycles(6, "R10 disabled R1");
    en = 1'b1;
    run_cycles(150, "R10 restart");
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0;
    set_geom(2, 1, 4, 2, 1, 1, 3, 1);
    hs_inv = 1'b0; vs_inv = 1'b0; de_inv = 1'b0; clk_inv = 1'b0;
    src_valid = 1'b1; src_data = 24'h5A0000;
    m_run = 0; m_ph = 0; m_h = 0; m_v = 0;
    m_hs = 0; m_vs = 0; m_de = 0; m_acc = 0; m_data = 0;
    m_load();
    t_reset();
    t_frames();
    t_polarity();
    t_midframe();
    t_zero_sync();
    t_underflow();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule